// File: doc/BRIEF.md
# Instruction Exception Classifier and Vector Encoder

This block sits in the execute stage of a processor core. Each cycle it looks at the decode results of the instruction in execute and at a few bits of machine state. It picks the single most urgent exception among seven kinds and reports it. Opcode decoding, checking of extension words and building of the exception stack frame are all done by other blocks.

The seven kinds are address error, illegal opcode, unimplemented line-A opcode, line-F opcode, privilege violation, divide-by-zero and trace. For the one it selects, the block gives the request, a class code, the vector number and the byte offset into the vector table. All of these are registered, so a request appears on the outputs one cycle after the inputs that caused it and lasts one cycle.

The address-error checks cover three cases: control transfers to odd addresses, indexed addressing with a word-sized index or a scale of eight, and full-format indexed addressing. A trace exception is raised when an instruction finishes with the trace bit set. An instruction that halts the core (STOP) raises no trace.

Top module: `exc_classifier`

## Requirements
- R1: With `ex_valid` high, a control transfer (`xfer_valid` high) whose `xfer_target` has bit 0 set raises an address error. The address error is vector 3, offset 0x00C, class code 1. An even target raises nothing.
- R2: With `ex_valid` and `idx_valid` high, a word-sized index (`idx_word`) or a scale code `idx_scale` of 3 raises an address error. Scale code 3 means a scale of eight. Scale codes 0 to 2 (scales of one, two and four) with a long index raise nothing. With `idx_valid` low, the index fields are ignored.
- R3: With `ex_valid` and `idx_valid` high, a full-format index (`idx_full`) raises an address error.
- R4: `op_illegal` raises vector 4 (class 2) only when neither `op_line_a` nor `op_line_f` is set. A line-A opcode flagged as a MAC operation (`op_line_a_mac`) raises nothing.
- R5: A line-A opcode that is not a MAC operation raises vector 10 (class 3). A line-F opcode raises vector 11 (class 4). Line-F takes precedence over line-A.
- R6: A supervisor-only instruction (`sup_only`) raises vector 8 (class 5) when `sup_mode` is low. It raises nothing when `sup_mode` is high.
- R7: A divide (`div_op`) with `div_zero` high raises vector 5 (class 6) at offset 0x014. A divide with a nonzero divisor raises nothing.
- R8: `insn_done` with `trace_bit` high raises vector 9 (class 7), whatever the value of `ex_valid`. There is no trace when `insn_stop` is high, and none when `trace_bit` is low.
- R9: `exc_off` always equals `exc_vec` times 4. With no request, `exc_vec`, `exc_off` and `exc_kind` are all zero.
- R10: When several conditions hold at once, the order is: address error, then opcode class (illegal, line-A or line-F), then privilege, then divide-by-zero, then trace.
- R11: Outputs are registered. They reflect the inputs of the previous cycle and are zero during reset. A request lasts one cycle unless the inputs raise it again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ex_valid | input | 1 | An instruction is in execute and its decode fields are valid |
| xfer_valid | input | 1 | The instruction transfers control |
| xfer_target | input | AW | Control-transfer target address |
| idx_valid | input | 1 | An indexed addressing mode is in use |
| idx_word | input | 1 | The index register is word-sized |
| idx_scale | input | SCALE_W | Scale code (log2 of the scale) |
| idx_full | input | 1 | Full-format indexed mode |
| op_illegal | input | 1 | Decoder flags an illegal 16-bit opcode |
| op_line_a | input | 1 | Opcode is in line A |
| op_line_a_mac | input | 1 | Line-A opcode is a MAC operation |
| op_line_f | input | 1 | Opcode is in line F |
| sup_only | input | 1 | Instruction needs supervisor mode |
| sup_mode | input | 1 | Core is in supervisor mode |
| div_op | input | 1 | Instruction is a divide |
| div_zero | input | 1 | Divisor is zero |
| insn_done | input | 1 | An instruction completes this cycle |
| insn_stop | input | 1 | The completing instruction is STOP |
| trace_bit | input | 1 | Status-register trace enable |
| exc_req | output | 1 | Exception request |
| exc_kind | output | 3 | Class code of the request |
| exc_vec | output | VEC_W | Vector number |
| exc_off | output | VEC_W+2 | Vector-table byte offset |

## Verification
The output register holds no state from one cycle to the next. So if the next-state logic picks the wrong kind or vector, it shows on the ports exactly one cycle after the inputs that cause it, and it is gone again in the cycle after that. Two faults need their own checks because they only appear when conditions overlap: a wrong priority order, and a request that leaks past its one cycle. The bench therefore presents conditions in pairs and follows each request with an idle cycle.

// File: rtl/exc_pkg.sv
package exc_pkg;

    typedef enum logic [2:0] {
        EK_NONE    = 3'd0,
        EK_ADDR    = 3'd1,
        EK_ILLEGAL = 3'd2,
        EK_LINE_A  = 3'd3,
        EK_LINE_F  = 3'd4,
        EK_PRIV    = 3'd5,
        EK_DIV0    = 3'd6,
        EK_TRACE   = 3'd7
    } exc_kind_e;

    localparam int unsigned VN_ADDR    = 3;
    localparam int unsigned VN_ILLEGAL = 4;
    localparam int unsigned VN_DIV0    = 5;
    localparam int unsigned VN_PRIV    = 8;
    localparam int unsigned VN_TRACE   = 9;
    localparam int unsigned VN_LINE_A  = 10;
    localparam int unsigned VN_LINE_F  = 11;

    function automatic int unsigned kind_vector(input exc_kind_e k);
        case (k)
            EK_ADDR:    return VN_ADDR;
            EK_ILLEGAL: return VN_ILLEGAL;
            EK_LINE_A:  return VN_LINE_A;
            EK_LINE_F:  return VN_LINE_F;
            EK_PRIV:    return VN_PRIV;
            EK_DIV0:    return VN_DIV0;
            EK_TRACE:   return VN_TRACE;
            default:    return 0;
        endcase
    endfunction

endpackage

// File: rtl/exc_addr_check.sv
module exc_addr_check #(
    parameter int AW      = 32,
    parameter int SCALE_W = 2
) (
    input  logic               ex_valid,
    input  logic               xfer_valid,
    input  logic [AW-1:0]      xfer_target,
    input  logic               idx_valid,
    input  logic               idx_word,
    input  logic [SCALE_W-1:0] idx_scale,
    input  logic               idx_full,
    output logic               addr_hit
);
    localparam int SCALE8_CODE = 3;

    logic odd_hit;
    logic scale8;
    logic idx_hit;

    generate
        if (SCALE_W >= 2) begin : g_scale8
            assign scale8 = (idx_scale == SCALE_W'(SCALE8_CODE));
        end else begin : g_no_scale8
            logic unused_scale;
            assign unused_scale = ^idx_scale;
            assign scale8 = 1'b0;
        end
    endgenerate

    logic unused_hi;
    assign unused_hi = ^xfer_target[AW-1:1];

    always_comb begin
        odd_hit  = xfer_valid & xfer_target[0];
        idx_hit  = idx_valid & (idx_word | scale8 | idx_full);
        addr_hit = ex_valid & (odd_hit | idx_hit);
    end
endmodule

// File: rtl/exc_opclass.sv
module exc_opclass
    import exc_pkg::*;
(
    input  logic      ex_valid,
    input  logic      op_illegal,
    input  logic      op_line_a,
    input  logic      op_line_a_mac,
    input  logic      op_line_f,
    output exc_kind_e op_kind
);
    always_comb begin
        op_kind = EK_NONE;
        if (ex_valid) begin
            if (op_line_f) begin
                op_kind = EK_LINE_F;
            end else if (op_line_a) begin
                op_kind = op_line_a_mac ? EK_NONE : EK_LINE_A;
            end else if (op_illegal) begin
                op_kind = EK_ILLEGAL;
            end
        end
    end
endmodule

// File: rtl/exc_select.sv
module exc_select
    import exc_pkg::*;
(
    input  logic      addr_hit,
    input  exc_kind_e op_kind,
    input  logic      priv_hit,
    input  logic      div_hit,
    input  logic      trace_hit,
    output exc_kind_e win_kind
);
    always_comb begin
        if (addr_hit)                win_kind = EK_ADDR;
        else if (op_kind != EK_NONE) win_kind = op_kind;
        else if (priv_hit)           win_kind = EK_PRIV;
        else if (div_hit)            win_kind = EK_DIV0;
        else if (trace_hit)          win_kind = EK_TRACE;
        else                         win_kind = EK_NONE;
    end
endmodule

// File: rtl/exc_classifier.sv
module exc_classifier
    import exc_pkg::*;
#(
    parameter int AW      = 32,
    parameter int SCALE_W = 2,
    parameter int VEC_W   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ex_valid,
    input  logic               xfer_valid,
    input  logic [AW-1:0]      xfer_target,
    input  logic               idx_valid,
    input  logic               idx_word,
    input  logic [SCALE_W-1:0] idx_scale,
    input  logic               idx_full,
    input  logic               op_illegal,
    input  logic               op_line_a,
    input  logic               op_line_a_mac,
    input  logic               op_line_f,
    input  logic               sup_only,
    input  logic               sup_mode,
    input  logic               div_op,
    input  logic               div_zero,
    input  logic               insn_done,
    input  logic               insn_stop,
    input  logic               trace_bit,
    output logic               exc_req,
    output logic [2:0]         exc_kind,
    output logic [VEC_W-1:0]   exc_vec,
    output logic [VEC_W+1:0]   exc_off
);
    localparam int OFF_W = VEC_W + 2;

    typedef struct packed {
        logic             req;
        exc_kind_e        kind;
        logic [VEC_W-1:0] vec;
        logic [OFF_W-1:0] off;
    } out_t;

    out_t      st_d, st_q;
    logic      addr_hit;
    exc_kind_e op_kind;
    exc_kind_e win_kind;
    logic      priv_hit;
    logic      div_hit;
    logic      trace_hit;

    exc_addr_check #(.AW(AW), .SCALE_W(SCALE_W)) u_addr (
        .ex_valid    (ex_valid),
        .xfer_valid  (xfer_valid),
        .xfer_target (xfer_target),
        .idx_valid   (idx_valid),
        .idx_word    (idx_word),
        .idx_scale   (idx_scale),
        .idx_full    (idx_full),
        .addr_hit    (addr_hit)
    );

    exc_opclass u_opc (
        .ex_valid      (ex_valid),
        .op_illegal    (op_illegal),
        .op_line_a     (op_line_a),
        .op_line_a_mac (op_line_a_mac),
        .op_line_f     (op_line_f),
        .op_kind       (op_kind)
    );

    always_comb begin
        priv_hit  = ex_valid & sup_only & ~sup_mode;
        div_hit   = ex_valid & div_op & div_zero;
        trace_hit = insn_done & ~insn_stop & trace_bit;
    end

    exc_select u_sel (
        .addr_hit  (addr_hit),
        .op_kind   (op_kind),
        .priv_hit  (priv_hit),
        .div_hit   (div_hit),
        .trace_hit (trace_hit),
        .win_kind  (win_kind)
    );

    always_comb begin
        st_d      = '0;
        st_d.req  = (win_kind != EK_NONE);
        st_d.kind = win_kind;
        st_d.vec  = VEC_W'(kind_vector(win_kind));
        st_d.off  = {st_d.vec, 2'b00};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign exc_req  = st_q.req;
    assign exc_kind = st_q.kind;
    assign exc_vec  = st_q.vec;
    assign exc_off  = st_q.off;

    // R1: odd transfer target yields vector 3 at offset 0x00C
    p_odd_target_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_valid && xfer_valid && xfer_target[0])
        |=> (exc_req && exc_vec == VEC_W'(3) && exc_off == OFF_W'(12)));

    // R6: supervisor-only instruction in supervisor mode alone raises nothing
    p_sup_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_valid && sup_only && sup_mode && !xfer_valid && !idx_valid &&
         !op_illegal && !op_line_a && !op_line_f && !div_op && !insn_done)
        |=> !exc_req);

    // R7: divide by zero alone gives vector 5 at offset 0x014
    p_div_vec_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_valid && div_op && div_zero && !xfer_valid && !idx_valid &&
         !op_illegal && !op_line_a && !op_line_f && !sup_only)
        |=> (exc_vec == VEC_W'(5) && exc_off == OFF_W'(20)));

    // R8: a completing STOP never produces a trace request
    p_stop_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_done && insn_stop && !ex_valid) |=> !exc_req);

    // R10: address error outranks an illegal opcode
    p_addr_first_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_valid && idx_valid && idx_full && op_illegal)
        |=> (exc_kind == 3'd1));

    // R11: with nothing in execute and no completion, next cycle is quiet
    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!ex_valid && !insn_done) |=> (!exc_req && exc_vec == '0));
endmodule

// File: tb/tb_exc_classifier.sv
module tb_exc_classifier;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        ex_valid, xfer_valid, idx_valid, idx_word, idx_full;
    logic [31:0] xfer_target;
    logic [1:0]  idx_scale;
    logic        op_illegal, op_line_a, op_line_a_mac, op_line_f;
    logic        sup_only, sup_mode, div_op, div_zero;
    logic        insn_done, insn_stop, trace_bit;
    logic        exc_req;
    logic [2:0]  exc_kind;
    logic [7:0]  exc_vec;
    logic [9:0]  exc_off;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    typedef struct {
        int    vec;
        string tag;
    } exp_t;
    exp_t q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    exc_classifier dut (
        .clk(clk), .rst_n(rst_n), .ex_valid(ex_valid), .xfer_valid(xfer_valid),
        .xfer_target(xfer_target), .idx_valid(idx_valid), .idx_word(idx_word),
        .idx_scale(idx_scale), .idx_full(idx_full), .op_illegal(op_illegal),
        .op_line_a(op_line_a), .op_line_a_mac(op_line_a_mac), .op_line_f(op_line_f),
        .sup_only(sup_only), .sup_mode(sup_mode), .div_op(div_op), .div_zero(div_zero),
        .insn_done(insn_done), .insn_stop(insn_stop), .trace_bit(trace_bit),
        .exc_req(exc_req), .exc_kind(exc_kind), .exc_vec(exc_vec), .exc_off(exc_off)
    );

    // class codes per R1..R8
    function automatic int vec_class(input int v);
        case (v)
            3:  return 1;
            4:  return 2;
            10: return 3;
            11: return 4;
            8:  return 5;
            5:  return 6;
            9:  return 7;
            default: return 0;
        endcase
    endfunction

    task automatic clr();
        ex_valid = 0; xfer_valid = 0; xfer_target = 32'h0; idx_valid = 0;
        idx_word = 0; idx_scale = 2'd0; idx_full = 0; op_illegal = 0;
        op_line_a = 0; op_line_a_mac = 0; op_line_f = 0; sup_only = 0;
        sup_mode = 0; div_op = 0; div_zero = 0; insn_done = 0;
        insn_stop = 0; trace_bit = 0;
    endtask

    // driver: inputs already set at this negedge; push expectation, advance
    task automatic go(input int vec, input string tag);
        exp_t e;
        e.vec = vec;
        e.tag = tag;
        q.push_back(e);
        @(negedge clk);
        clr();
    endtask

    task automatic check(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // monitor: compares each pushed item one edge later
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                check({e.tag, " req (R11)"}, int'(exc_req), (e.vec != 0) ? 1 : 0);
                check({e.tag, " vec"}, int'(exc_vec), e.vec);
                check({e.tag, " off (R9)"}, int'(exc_off), e.vec * 4);
                check({e.tag, " kind (R9)"}, int'(exc_kind), vec_class(e.vec));
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        clr();
        rst_n = 0;
        ex_valid = 1; xfer_valid = 1; xfer_target = 32'h1;
        repeat (3) @(negedge clk);
        check("R11 reset req", int'(exc_req), 0);
        check("R11 reset vec", int'(exc_vec), 0);
        rst_n = 1;
        clr();
        @(negedge clk);

        ex_valid = 1; xfer_valid = 1; xfer_target = 32'h0000_1235; go(3, "R1 odd target");
        ex_valid = 1; xfer_valid = 1; xfer_target = 32'h0000_1234; go(0, "R1 even target");
        ex_valid = 0; xfer_valid = 1; xfer_target = 32'h0000_0001; go(0, "R1 not in execute");
        ex_valid = 1; idx_valid = 1; idx_word = 1;                go(3, "R2 word index");
        ex_valid = 1; idx_valid = 1; idx_scale = 2'd3;            go(3, "R2 scale eight");
        ex_valid = 1; idx_valid = 1; idx_scale = 2'd2;            go(0, "R2 scale four");
        ex_valid = 1; idx_valid = 0; idx_word = 1; idx_scale = 2'd3; idx_full = 1;
        go(0, "R2 index fields ignored");
        ex_valid = 1; idx_valid = 1; idx_full = 1;                go(3, "R3 full format");
        ex_valid = 1; op_illegal = 1;                             go(4, "R4 illegal");
        ex_valid = 1; op_illegal = 1; op_line_a = 1; op_line_a_mac = 1;
        go(0, "R4 mac line-A quiet");
        ex_valid = 1; op_line_a = 1;                              go(10, "R5 line-A");
        ex_valid = 1; op_line_f = 1;                              go(11, "R5 line-F");
        ex_valid = 1; op_line_f = 1; op_line_a = 1;               go(11, "R5 line-F over line-A");
        ex_valid = 1; sup_only = 1; sup_mode = 0;                 go(8, "R6 user priv");
        ex_valid = 1; sup_only = 1; sup_mode = 1;                 go(0, "R6 supervisor ok");
        ex_valid = 1; div_op = 1; div_zero = 1;                   go(5, "R7 divide by zero");
        ex_valid = 1; div_op = 1; div_zero = 0;                   go(0, "R7 nonzero divisor");
        insn_done = 1; trace_bit = 1;                             go(9, "R8 trace");
        insn_done = 1; trace_bit = 1; insn_stop = 1;              go(0, "R8 stop no trace");
        insn_done = 1; trace_bit = 0;                             go(0, "R8 trace off");
        ex_valid = 1; xfer_valid = 1; xfer_target = 32'h3; op_line_f = 1;
        go(3, "R10 addr over line-F");
        ex_valid = 1; op_illegal = 1; sup_only = 1;               go(4, "R10 illegal over priv");
        ex_valid = 1; sup_only = 1; div_op = 1; div_zero = 1;     go(8, "R10 priv over div");
        ex_valid = 1; div_op = 1; div_zero = 1; insn_done = 1; trace_bit = 1;
        go(5, "R10 div over trace");
        go(0, "R11 pulse drops");
        ex_valid = 1; op_line_a = 1;                              go(10, "R11 back to back a");
        ex_valid = 1; op_line_a = 1;                              go(10, "R11 back to back b");
        go(0, "R11 idle");
        @(negedge clk);
        @(negedge clk);

        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule